// File: doc/BRIEF.md
# Multimode Timer with Dual Capture

This block is a counter pair of two equal halves that a 2-bit mode register puts into one of four arrangements. It can run as two independent prescaled timers, as a prescaled timer beside an event counter, as one cascaded double-width timer, or as one double-width event counter. Each half wraps to zero after it reaches its programmed match value and sets a sticky match flag. Software clears that flag by writing a one to it.

Two capture inputs each own a double-width capture register. A rising edge on a capture input copies the whole counter pair into that register. In the split modes the low byte of each capture register belongs to the low half and the high byte belongs to the high half. In the wide modes the register holds the full count. A small write port loads the mode, the prescaler values, the match values and the flag clears. A read selector returns the live count, either capture register, or the flags.

Top module: `dual_capture_timer`

## Requirements
- R1: While reset is low, the count, both capture registers, the flags, the mode, the prescaler values and the match values are all zero.
- R2: A prescaler value N makes its timer advance once every N+1 clocks, and N = 0 means once per clock. A write to a prescaler value restarts that prescaler. A write to the mode restarts both prescalers. After such a write the first advance comes N+1 clocks later.
- R3: Mode 0 (split) runs the low and high halves as separate timers. The low half is clocked by the low prescaler and the high half by the high prescaler.
- R4: Mode 1 advances the low half from the low prescaler. The high half advances by one for each rising edge of the event input.
- R5: Mode 2 (cascade) runs one double-width timer from the low prescaler. The high half advances when the low half carries out of all-ones. The match compares the full width, and a wrap sets only the high flag.
- R6: Mode 3 runs one double-width counter that advances once per event rising edge. It holds its value while no edge arrives, and a wrap sets only the high flag.
- R7: When an advance finds a counter equal to its match value, that counter becomes zero instead of incrementing, so the period is match+1 advances. The same advance sets the matching flag.
- R8: The event and capture inputs pass through two synchronising flip-flops, and only rising edges act. An input that rises before clock edge k acts at edge k+2. An input held high produces one action.
- R9: A rising edge on capture input A loads capture register A with the full counter pair, high half above low half. Input B does the same for register B, and each register is otherwise held.
- R10: A capture that falls in the same clock as a counter wrap stores the value from before the wrap.
- R11: The flags stay set until a flag-clear write with a one in the flag's bit. When a set and a clear fall in the same clock, the set wins.
- R12: Write addresses are 0 = mode in bits [1:0], 1 = low prescaler, 2 = high prescaler, 3 = low match, 4 = high match and 5 = flag clear, with bit 0 for low and bit 1 for high. Read selects are 0 = count {high,low}, 1 = capture A, 2 = capture B and 3 = flags, with high in bit 1 and low in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | HW (8) | Register write data |
| rd_sel | input | 2 | Read source select |
| rd_data | output | 2*HW (16) | Selected read value |
| evt_in | input | 1 | External event input |
| cap_a_in | input | 1 | Capture A trigger |
| cap_b_in | input | 1 | Capture B trigger |
| irq_lo | output | 1 | Low-part match flag |
| irq_hi | output | 1 | High-part match flag |

## Verification
The hardest case to reach from the ports is a capture edge that lands on exactly the clock in which the counter wraps. Synchronisation delays the capture input, and the timer runs freely from reset. To control the timing, the stimulus first places the block in the event-counter mode with no events, where it stands still. It then programs every register and makes the mode write last. That write restarts the prescalers, so every later count is a fixed function of the clocks since that write. The capture input can then be raised two clocks before the computed wrap edge.

// File: rtl/dct_pkg.sv
package dct_pkg;
   typedef enum logic [1:0] {
      MODE_SPLIT   = 2'd0,
      MODE_TMR_EVT = 2'd1,
      MODE_CASC    = 2'd2,
      MODE_EVT16   = 2'd3
   } dct_mode_e;

   localparam logic [2:0] A_MODE     = 3'd0;
   localparam logic [2:0] A_PRE_LO   = 3'd1;
   localparam logic [2:0] A_PRE_HI   = 3'd2;
   localparam logic [2:0] A_MATCH_LO = 3'd3;
   localparam logic [2:0] A_MATCH_HI = 3'd4;
   localparam logic [2:0] A_FLAGS    = 3'd5;

   localparam logic [1:0] RD_COUNT = 2'd0;
   localparam logic [1:0] RD_CAP_A = 2'd1;
   localparam logic [1:0] RD_CAP_B = 2'd2;
   localparam logic [1:0] RD_FLAGS = 2'd3;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [PW-1:0] div,
   output logic          tick
);
   logic [PW-1:0] phase_q;

   assign tick = (phase_q == div);

   always_ff @(posedge clk) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else if (tick)    phase_q <= '0;
      else              phase_q <= phase_q + 1'b1;
   end

   // R2: with a nonzero divisor two ticks never come back to back
   assert_prescale_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/dct_edge_sync.sv
module dct_edge_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [2:0] pipe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[1:0], din};
   end

   assign rise = pipe_q[1] & ~pipe_q[2];

   // R8: an edge produces exactly one single-cycle pulse
   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/dct_half.sv
module dct_half #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
   import dct_pkg::*;
#(
   parameter int HW = 8,
   parameter int PW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [2:0]      wr_addr,
   input  logic [HW-1:0]   wr_data,
   input  logic [1:0]      rd_sel,
   output logic [2*HW-1:0] rd_data,
   input  logic            evt_in,
   input  logic            cap_a_in,
   input  logic            cap_b_in,
   output logic            irq_lo,
   output logic            irq_hi
);
   localparam int FW = 2 * HW;

   if (HW < 2 || PW < 1 || PW > HW) begin : g_bad_params
      $error("dual_capture_timer: need HW >= 2 and 1 <= PW <= HW");
   end

   dct_mode_e             mode_q;
   logic [1:0][PW-1:0]    pre_q;
   logic [1:0][HW-1:0]    match_q;
   logic [1:0][HW-1:0]    cnt;
   logic [FW-1:0]         cnt_all, match_all;
   logic [1:0][FW-1:0]    cap_q;
   logic [1:0]            pre_tick, restart, inc, clr;
   logic [2:0]            ext_in, ext_rise;
   logic                  wide, eq_lo, eq_hi, tick_lo, tick_hi, tick16, wrap16;
   logic                  set_lo, set_hi, clr_lo_w, clr_hi_w;

   assign ext_in = {cap_b_in, cap_a_in, evt_in};

   for (genvar s = 0; s < 3; s++) begin : g_sync
      dct_edge_sync u_sync (.clk(clk), .rst_n(rst_n), .din(ext_in[s]), .rise(ext_rise[s]));
   end

   for (genvar h = 0; h < 2; h++) begin : g_part
      assign restart[h] = wr_en &&
         (wr_addr == A_MODE || wr_addr == ((h == 0) ? A_PRE_LO : A_PRE_HI));
      dct_prescaler #(.PW(PW)) u_pre (
         .clk(clk), .rst_n(rst_n), .restart(restart[h]),
         .div(pre_q[h]), .tick(pre_tick[h]));
      dct_half #(.W(HW)) u_half (
         .clk(clk), .rst_n(rst_n), .inc(inc[h]), .clr(clr[h]), .cnt(cnt[h]));
   end

   assign cnt_all   = cnt;
   assign match_all = match_q;
   assign wide      = mode_q[1];
   assign eq_lo     = (cnt[0] == match_q[0]);
   assign eq_hi     = (cnt[1] == match_q[1]);
   assign tick_lo   = pre_tick[0];
   assign tick_hi   = (mode_q == MODE_SPLIT) ? pre_tick[1] : ext_rise[0];
   assign tick16    = (mode_q == MODE_CASC) ? pre_tick[0] : ext_rise[0];
   assign wrap16    = tick16 && eq_lo && eq_hi;

   always_comb begin
      if (wide) begin
         inc[0] = tick16;
         clr[0] = wrap16;
         inc[1] = tick16 && (&cnt[0]);
         clr[1] = wrap16;
         set_lo = 1'b0;
         set_hi = wrap16;
      end else begin
         inc[0] = tick_lo;
         clr[0] = tick_lo && eq_lo;
         inc[1] = tick_hi;
         clr[1] = tick_hi && eq_hi;
         set_lo = tick_lo && eq_lo;
         set_hi = tick_hi && eq_hi;
      end
   end

   assign clr_lo_w = wr_en && (wr_addr == A_FLAGS) && wr_data[0];
   assign clr_hi_w = wr_en && (wr_addr == A_FLAGS) && wr_data[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_SPLIT;
         pre_q   <= '0;
         match_q <= '0;
         irq_lo  <= 1'b0;
         irq_hi  <= 1'b0;
      end else begin
         if (wr_en) begin
            case (wr_addr)
               A_MODE:     mode_q     <= dct_mode_e'(wr_data[1:0]);
               A_PRE_LO:   pre_q[0]   <= wr_data[PW-1:0];
               A_PRE_HI:   pre_q[1]   <= wr_data[PW-1:0];
               A_MATCH_LO: match_q[0] <= wr_data;
               A_MATCH_HI: match_q[1] <= wr_data;
               default: ;
            endcase
         end
         irq_lo <= set_lo | (irq_lo & ~clr_lo_w);
         irq_hi <= set_hi | (irq_hi & ~clr_hi_w);
      end
   end

   for (genvar c = 0; c < 2; c++) begin : g_cap
      always_ff @(posedge clk) begin
         if (!rst_n)              cap_q[c] <= '0;
         else if (ext_rise[c+1])  cap_q[c] <= cnt_all;
      end
   end

   always_comb begin
      case (rd_sel)
         RD_COUNT: rd_data = cnt_all;
         RD_CAP_A: rd_data = cap_q[0];
         RD_CAP_B: rd_data = cap_q[1];
         default:  rd_data = {{(FW-2){1'b0}}, irq_hi, irq_lo};
      endcase
   end

   // R9: a capture A edge stores the count seen in that cycle
   assert_capture_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise[1] |=> cap_q[0] == $past(cnt_all));
   // R10: capture B during a wrap keeps the pre-wrap value
   assert_capture_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rise[2] && (clr[0] || clr[1])) |=> cap_q[1] == $past(cnt_all));
   // R7: split-mode low half returns to zero with its flag on a match
   assert_split_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide && tick_lo && eq_lo) |=> (cnt[0] == '0 && irq_lo));
   // R11: a clear without a coincident set drops the flag
   assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_lo_w && !set_lo) |=> !irq_lo);
   // R6: event mode holds the count when no edge arrives
   assert_evt16_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_EVT16 && !ext_rise[0]) |=> $stable(cnt_all));
   // R5: cascade carries into the high half
   assert_casc_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_CASC && tick16 && cnt_all != match_all && (&cnt[0]))
      |=> cnt[1] == HW'($past(cnt[1]) + 1'b1));
endmodule

// File: tb/dual_capture_timer_test.sv
module dual_capture_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [15:0] rd_data;
   logic        evt_in = 1'b0, cap_a_in = 1'b0, cap_b_in = 1'b0;
   logic        irq_lo, irq_hi;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [1:0]  sel;
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t q[$];

   always #5 clk = ~clk;

   dual_capture_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .evt_in(evt_in), .cap_a_in(cap_a_in),
      .cap_b_in(cap_b_in), .irq_lo(irq_lo), .irq_hi(irq_hi));

   // monitor: compares the head of the scoreboard against the read port
   initial begin
      forever begin
         wait (q.size() != 0);
         n_cmp++;
         if (rd_data !== q[0].exp) begin
            n_bad++;
            $display("FAIL %s: sel=%0d actual=%h expected=%h",
                     q[0].tag, q[0].sel, rd_data, q[0].exp);
         end
         void'(q.pop_front());
      end
   end

   task automatic chk(input logic [1:0] sel, input logic [15:0] exp, input string tag);
      rd_sel = sel;
      #1;
      q.push_back('{sel, exp, tag});
      wait (q.size() == 0);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      evt_in = 1'b0; cap_a_in = 1'b0; cap_b_in = 1'b0; wr_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // park in event mode, program everything, start with the mode write (t = 0 on return)
   task automatic setup(input logic [7:0] pl, input logic [7:0] ph,
                        input logic [7:0] ml, input logic [7:0] mh, input logic [1:0] m);
      do_reset();
      wr(3'd0, 8'd3);
      wr(3'd5, 8'd3);
      wr(3'd3, ml);
      wr(3'd4, mh);
      wr(3'd1, pl);
      wr(3'd2, ph);
      wr(3'd0, {6'd0, m});
   endtask

   task automatic pulse_evt();
      evt_in = 1'b1; @(negedge clk);
      evt_in = 1'b0; @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      @(negedge clk); @(negedge clk);
      chk(2'd0, 16'h0000, "R1 count in reset");
      chk(2'd1, 16'h0000, "R1 capture A in reset");
      chk(2'd2, 16'h0000, "R1 capture B in reset");
      @(negedge clk);
      chk(2'd3, 16'h0000, "R1 flags in reset");

      // R3 split mode, R2 prescale 0 and 2, R7 wrap, R11 flags, R12 map
      setup(8'd0, 8'd2, 8'd5, 8'd200, 2'd0);
      repeat (4) @(negedge clk);
      chk(2'd0, 16'h0104, "R3 R2 split halves at t=4");
      repeat (2) @(negedge clk);
      chk(2'd0, 16'h0200, "R7 low wraps after match at t=6");
      chk(2'd3, 16'h0001, "R12 low flag in bit 0");
      @(negedge clk);
      wr(3'd5, 8'd1);
      chk(2'd3, 16'h0000, "R11 flag cleared by write of one");
      repeat (3) @(negedge clk);
      wr(3'd5, 8'd1);
      chk(2'd3, 16'h0001, "R11 set wins over clear");
      chk(2'd0, 16'h0400, "R2 high prescaler at t=12");

      // R4 timer plus event counter, R8 synchroniser latency
      setup(8'd1, 8'd0, 8'd255, 8'd255, 2'd1);
      for (int i = 0; i < 3; i++) begin
         evt_in = 1'b1; repeat (4) @(negedge clk);
         evt_in = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(2'd0, 16'h030E, "R4 three events counted, low prescaled");
      evt_in = 1'b1;
      repeat (2) @(negedge clk);
      chk(2'd0, 16'h030F, "R8 no count before second sync stage");
      @(negedge clk);
      chk(2'd0, 16'h040F, "R8 count on third edge after rise");
      evt_in = 1'b0;

      // R5 cascaded 16-bit timer, match 0x0102
      setup(8'd0, 8'd0, 8'h02, 8'h01, 2'd2);
      repeat (3) @(negedge clk);
      chk(2'd0, 16'h0003, "R5 low byte match alone does not wrap");
      repeat (253) @(negedge clk);
      chk(2'd0, 16'h0100, "R5 carry into high half");
      repeat (3) @(negedge clk);
      chk(2'd0, 16'h0000, "R5 full-width wrap");
      chk(2'd3, 16'h0002, "R5 only high flag set");

      // R6 16-bit event counter, match 3
      setup(8'd0, 8'd0, 8'h03, 8'h00, 2'd3);
      for (int i = 0; i < 3; i++) pulse_evt();
      repeat (4) @(negedge clk);
      chk(2'd0, 16'h0003, "R6 three events");
      chk(2'd3, 16'h0000, "R6 no flag before match");
      pulse_evt();
      repeat (4) @(negedge clk);
      chk(2'd0, 16'h0000, "R6 wrap after match");
      chk(2'd3, 16'h0002, "R6 high flag on wrap");

      // R9 capture, R10 capture at wrap (split mode, low match 9)
      setup(8'd0, 8'd0, 8'd9, 8'd255, 2'd0);
      cap_a_in = 1'b1;
      repeat (3) @(negedge clk);
      cap_a_in = 1'b0;
      repeat (2) @(negedge clk);
      chk(2'd1, 16'h0202, "R9 capture A holds count");
      chk(2'd2, 16'h0000, "R9 capture B untouched");
      repeat (2) @(negedge clk);
      cap_b_in = 1'b1;
      repeat (4) @(negedge clk);
      chk(2'd2, 16'h0909, "R10 capture at wrap keeps pre-wrap value");
      chk(2'd1, 16'h0202, "R9 capture A held");
      chk(2'd0, 16'h0B01, "R7 count after wrap");
      cap_b_in = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule